// File: doc/BRIEF.md
# Ternary-Weight Dot-Product Accumulator

This block forms the integer dot product of a stream of signed 8-bit activations with a stream of ternary weights. Each weight is -1, 0 or +1 and is carried as a 2-bit code. Sixteen codes are packed side by side in one weight word. Every accepted beat carries sixteen activation lanes and sixteen weight codes. Each lane either passes its activation, negates it, or drops it. A balanced adder tree reduces the lanes to a beat sum. The datapath holds no multiplier, only sign flips and additions.

A wide signed accumulator folds beat sums together. A beat flagged as first restarts the running sum. A beat flagged as last closes the vector, and the total appears on the output with a one-cycle valid pulse. Beats enter through a ready/valid handshake, one per cycle. The closing result sits in its own register, so a new vector may begin in the cycle right after the previous one closes.

Top module: `tern_dot_acc`

## Requirements
- R1: A lane whose weight code is 2'b00 (weight 0) adds nothing to the sum.
- R2: A lane whose weight code is 2'b01 (weight +1) adds its activation, read as a signed 8-bit value, to the sum.
- R3: A lane whose weight code is 2'b11 (weight -1) subtracts its activation from the sum.
- R4: The reserved code 2'b10 acts exactly like weight 0.
- R5: A beat accepted with `in_first` high discards any earlier partial sum, so the new total holds only that beat and the beats that follow it.
- R6: In the cycle after a beat is accepted with `in_last` high, `out_valid` is high for exactly that one cycle and `out_sum` holds the vector total. In every other cycle `out_valid` is low.
- R7: A cycle in which `in_valid` is low changes nothing, whatever the data, code and flag inputs hold.
- R8: While reset is held, and in the first cycle after reset is released, `out_valid` is low. From the first clock edge after reset, `in_ready` is high.
- R9: The sum is 32-bit signed and does not wrap for vectors of up to 2^16 elements. This includes the case of activation -128 with weight -1, which contributes +128.
- R10: A beat with both `in_first` and `in_last` high yields that beat's sum alone.
- R11: The first beat of a new vector may be accepted in the cycle where the previous result is shown, and both results come out correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present on the inputs |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_first | input | 1 | Beat opens a new vector |
| in_last | input | 1 | Beat closes the vector |
| in_act | input | 128 | Sixteen signed 8-bit activations; lane k at bits [8k+7:8k] |
| in_wcode | input | 32 | Sixteen 2-bit weight codes; lane k at bits [2k+1:2k] |
| out_valid | output | 1 | One-cycle pulse carrying a vector total |
| out_sum | output | 32 | Signed dot-product total |

## Verification
Two functions can land in the same cycle. One is the presentation of a finished total. The other is the clearing of the accumulator by the first beat of the next vector. The bench provokes this in two ways. It sends vectors back to back with no idle cycle, and it sends a run of beats that each carry both first and last. At every cycle a bench model predicts whether a total is due and what it is, and that prediction is compared with the output pulse. The bench also leaves a vector open without a last beat and restarts it, then sends invalid beats whose flags and codes are deliberately set, to show that only an accepted first beat clears the sum.

// File: rtl/tern_pkg.sv
package tern_pkg;

  // Activation width per lane and the width of one signed lane term.
  localparam int ACT_W  = 8;
  localparam int TERM_W = ACT_W + 1;
  localparam int CODE_W = 2;

  // Weight codes; the reserved value counts as a zero weight.
  typedef enum logic [CODE_W-1:0] {
    W_ZERO = 2'b00,
    W_POS  = 2'b01,
    W_RSVD = 2'b10,
    W_NEG  = 2'b11
  } wcode_e;

  // Sign-select one activation by its ternary code (no multiply).
  function automatic logic signed [TERM_W-1:0] lane_term(
    input logic [CODE_W-1:0]       code,
    input logic signed [ACT_W-1:0] act
  );
    logic signed [TERM_W-1:0] wide;
    wide = TERM_W'(act);
    case (code)
      W_POS:   return wide;
      W_NEG:   return -wide;
      default: return '0;
    endcase
  endfunction

  // True when a code contributes nothing.
  function automatic logic is_idle_code(input logic [CODE_W-1:0] code);
    return (code == W_ZERO) || (code == W_RSVD);
  endfunction

endpackage

// File: rtl/tern_lane.sv
module tern_lane
  import tern_pkg::*;
(
  input  logic [CODE_W-1:0]       code,
  input  logic signed [ACT_W-1:0] act,
  output logic signed [TERM_W-1:0] term
);

  always_comb term = lane_term(code, act);

endmodule

// File: rtl/tern_add_tree.sv
module tern_add_tree #(
  parameter int LANES = 16,             // power of two
  parameter int IN_W  = 9,
  localparam int DEPTH = $clog2(LANES),
  localparam int OUT_W = IN_W + DEPTH
) (
  input  logic [LANES*IN_W-1:0]    terms,
  output logic signed [OUT_W-1:0]  sum
);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int N = LANES >> l;
    logic signed [OUT_W-1:0] s [N];
    if (l == 0) begin : g_leaf
      for (genvar k = 0; k < N; k++) begin : g_in
        logic signed [IN_W-1:0] t;
        assign t    = terms[k*IN_W +: IN_W];
        assign s[k] = OUT_W'(t);
      end
    end else begin : g_node
      for (genvar k = 0; k < N; k++) begin : g_add
        assign s[k] = g_lvl[l-1].s[2*k] + g_lvl[l-1].s[2*k+1];
      end
    end
  end

  assign sum = g_lvl[DEPTH].s[0];

endmodule

// File: rtl/tern_accum.sv
module tern_accum #(
  parameter int SUM_W = 13,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic                    first,
  input  logic                    last,
  input  logic signed [SUM_W-1:0] beat_sum,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_sum
);

  function automatic logic signed [ACC_W-1:0] fold(
    input logic                    restart,
    input logic signed [ACC_W-1:0] prev,
    input logic signed [SUM_W-1:0] add
  );
    logic signed [ACC_W-1:0] base;
    base = restart ? '0 : prev;
    return base + ACC_W'(add);
  endfunction

  logic signed [ACC_W-1:0] acc_next;
  logic                    close_evt;

  always_comb begin
    acc_next  = fold(first, acc_q, beat_sum);
    close_evt = fire && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      res_valid <= 1'b0;
      res_sum   <= '0;
    end else begin
      res_valid <= close_evt;
      if (fire) acc_q <= acc_next;
      if (close_evt) res_sum <= acc_next;
    end
  end

  p_first_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && first) |=> (acc_q == ACC_W'($past(beat_sum))));

  p_acc_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !first) |=> (acc_q == $past(acc_q) + ACC_W'($past(beat_sum))));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc_q));

  p_pulse_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> res_valid);

  p_pulse_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && last) |=> !res_valid);

  p_result_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_sum == acc_q));

endmodule

// File: rtl/tern_dot_acc.sv
module tern_dot_acc
  import tern_pkg::*;
#(
  parameter int LANES = 16,
  parameter int ACC_W = 32,
  localparam int SUM_W = TERM_W + $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_first,
  input  logic                   in_last,
  input  logic [LANES*ACT_W-1:0] in_act,
  input  logic [LANES*2-1:0]     in_wcode,
  output logic                   out_valid,
  output logic [ACC_W-1:0]       out_sum
);

  // Named internal events for the assertions.
  logic                    ready_q;
  logic                    beat_fire;
  logic                    all_idle;
  logic [LANES*TERM_W-1:0] lane_terms;
  logic signed [SUM_W-1:0] tree_sum;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] res_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready  = ready_q;
  assign beat_fire = in_valid && ready_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [TERM_W-1:0] t;
    tern_lane u_lane (
      .code (in_wcode[k*2 +: 2]),
      .act  (in_act[k*ACT_W +: ACT_W]),
      .term (t)
    );
    assign lane_terms[k*TERM_W +: TERM_W] = t;
  end

  always_comb begin
    all_idle = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (!is_idle_code(in_wcode[k*2 +: 2])) all_idle = 1'b0;
  end

  tern_add_tree #(.LANES(LANES), .IN_W(TERM_W)) u_tree (
    .terms (lane_terms),
    .sum   (tree_sum)
  );

  tern_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (beat_fire),
    .first     (in_first),
    .last      (in_last),
    .beat_sum  (tree_sum),
    .acc_q     (acc_q),
    .res_valid (out_valid),
    .res_sum   (res_sum)
  );

  assign out_sum = res_sum;

  // R1/R4: a beat of only zero or reserved codes sums to nothing.
  p_zero_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && all_idle) |-> (tree_sum == '0));

  // R9: magnitude of one beat is bounded by LANES*128.
  p_beat_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |-> ((tree_sum <= SUM_W'(LANES*128)) && (tree_sum >= -SUM_W'(LANES*128))));

  // R8: no result pulse in the first cycle out of reset.
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> !out_valid);

endmodule

// File: tb/sim_tern_dot_acc.sv
module sim_tern_dot_acc;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [LANES*8-1:0] in_act = '0;
  logic [LANES*2-1:0] in_wcode = '0;
  logic in_ready, out_valid;
  logic [31:0] out_sum;

  int checks = 0, errors = 0;
  string cur_req = "R8";
  longint model_acc = 0;
  bit pend_valid = 0;
  longint pend_sum = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tern_dot_acc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_act(in_act),
    .in_wcode(in_wcode), .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare outputs against what the previous edge should have produced.
  task automatic check_out();
    check({cur_req, " R6 valid"}, out_valid, pend_valid);
    if (pend_valid)
      check({cur_req, " sum"}, longint'($signed(out_sum)), pend_sum);
  endtask

  // kind: 0 random codes, 1 all 00, 2 all 01, 3 all 11, 4 all 10,
  //       5 act -128 with 11, 6 act 127 with 11
  task automatic step(bit v, bit f, bit l, int kind);
    longint bsum;
    @(negedge clk);
    check_out();
    bsum = 0;
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] a;
      logic [1:0] c;
      int w;
      a = 8'($urandom);
      case (kind)
        1: c = 2'b00;
        2: c = 2'b01;
        3: c = 2'b11;
        4: c = 2'b10;
        5: begin c = 2'b11; a = 8'h80; end
        6: begin c = 2'b11; a = 8'h7f; end
        default: c = 2'($urandom);
      endcase
      in_act[k*8 +: 8]  = a;
      in_wcode[k*2 +: 2] = c;
      w = (c == 2'b01) ? 1 : ((c == 2'b11) ? -1 : 0);
      bsum += w * longint'($signed(a));
    end
    in_valid = v; in_first = f; in_last = l;
    pend_valid = 0;
    if (v) begin
      if (f) model_acc = 0;
      model_acc += bsum;
      if (l) begin pend_valid = 1; pend_sum = model_acc; end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, $urandom_range(0,1), $urandom_range(0,1), 0);
  endtask

  task automatic t_reset();
    cur_req = "R8";
    check("R8 out_valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    check("R8 out_valid after release", out_valid, 0);
    @(negedge clk);
    check("R8 in_ready", in_ready, 1);
    check("R8 out_valid", out_valid, 0);
  endtask

  task automatic t_codes();
    cur_req = "R1"; step(1, 1, 0, 1); step(1, 0, 1, 1); idle(1);
    cur_req = "R2"; step(1, 1, 0, 2); step(1, 0, 1, 2); idle(1);
    cur_req = "R3"; step(1, 1, 0, 3); step(1, 0, 1, 3); idle(1);
    cur_req = "R4"; step(1, 1, 0, 4); step(1, 0, 0, 4); step(1, 0, 1, 4); idle(2);
  endtask

  task automatic t_mixed();
    cur_req = "R2 R3 mixed";
    for (int r = 0; r < 4; r++) begin
      step(1, 1, 0, 0);
      for (int b = 0; b < 6; b++) step(1, 0, 0, 0);
      step(1, 0, 1, 0);
      idle(2);
    end
  endtask

  task automatic t_gap();
    cur_req = "R7";
    step(1, 1, 0, 0); idle(3);
    step(1, 0, 0, 0); idle(2);
    step(1, 0, 1, 0); idle(3);
  endtask

  task automatic t_clear();
    cur_req = "R5";
    step(1, 1, 0, 2); step(1, 0, 0, 2); step(1, 0, 0, 0);
    step(1, 1, 0, 3); step(1, 0, 1, 0); idle(2);
  endtask

  task automatic t_single();
    cur_req = "R10";
    for (int i = 0; i < 6; i++) step(1, 1, 1, 0);
    idle(2);
  endtask

  task automatic t_back2back();
    cur_req = "R11";
    for (int v = 0; v < 5; v++) begin
      step(1, 1, 0, 0); step(1, 0, 0, 0); step(1, 0, 1, 0);
    end
    step(1, 1, 1, 0); step(1, 1, 0, 0); step(1, 0, 1, 0);
    idle(2);
  endtask

  task automatic t_big();
    cur_req = "R9 positive";
    step(1, 1, 0, 5);
    for (int b = 0; b < 298; b++) step(1, 0, 0, 5);
    step(1, 0, 1, 5); idle(1);
    check("R9 total 614400", pend_sum, 614400);
    cur_req = "R9 negative";
    step(1, 1, 0, 6);
    for (int b = 0; b < 298; b++) step(1, 0, 0, 6);
    step(1, 0, 1, 6); idle(1);
    check("R9 total -609600", pend_sum, -609600);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_codes();
    t_mixed();
    t_gap();
    t_clear();
    t_single();
    t_back2back();
    t_big();
    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule